// File: doc/BRIEF.md
# Display Control Bus Master

This block sits on the graphics side of a narrow, byte-wide control bus that reaches the display chips: the timing generator, the colour look-up tables and the mode mappers. The host first programs a 32-bit mode word. That word names the target chip and a 3-bit register sub-address, and it sets how many bytes go per data word. It also sets the byte order, whether the sub-address steps after every byte, which acknowledge style ends a strobe, and how many clock cycles the chip-select setup, strobe width and hold take. One host data access then moves the whole word as a burst of byte transfers.

A data write sends the bytes of the word starting from the most significant byte. A data read collects the returned bytes into the same left-justified positions. The result appears on a read-data port once the burst has finished. `busy` stays high for the whole burst. A mode write or a second data access made while `busy` is high has no effect. If an acknowledged strobe gets no answer within a fixed number of cycles, the burst is abandoned and a sticky error flag is raised.

Top module: `dispbus_master`

## Requirements
- R1: After reset, `busy`, `bus_cs`, `bus_strobe` and `ack_err` are low and `rd_data` is zero.
- R2: Mode bits [1:0] give the bytes per access: 0 means 4, and 1, 2 or 3 mean that many bytes. When mode bit 2 is set, 4 bytes are moved whatever bits [1:0] hold.
- R3: Write bytes are taken left-justified from `dat_wdata`. Byte k of a burst (k counted from 0) comes from bits [31-8k:24-8k].
- R4: When mode bit 28 is set, the byte order within the burst is reversed over the same left-justified positions, and `bus_swap` is high.
- R5: `bus_sub` shows mode bits [6:4]. When mode bit 3 is set, the value steps by one modulo 8 after each completed byte, and the new value stays in effect for later bursts.
- R6: `bus_slave` shows mode bits [10:7], and `bus_cs` is high for the whole burst. Slave code 15 never raises `bus_cs` or `bus_strobe`. Its burst still runs on programmed timing and does not wait for an acknowledge.
- R7: Each byte has three phases. Setup lasts S cycles (mode bits [27:23]), the strobe lasts max(W,1) cycles (mode bits [17:13]) and hold lasts H cycles (mode bits [22:18]). A phase with a zero count is skipped, so an unacknowledged burst keeps `busy` high for n*(S+max(W,1)+H) cycles.
- R8: When mode bit 11 is set, `bus_ack_sync` sampled high ends the strobe at that clock edge. When mode bit 12 is set, `bus_ack_async` ends the strobe after a two-stage synchronizer, which is two cycles later.
- R9: An acknowledged strobe with no acknowledge for 256 cycles ends the burst with no hold phase. `ack_err` then goes high and stays high until reset.
- R10: A read returns its bytes into `rd_data` in the same left-justified (or reversed) positions, with unused low bytes zero. `rd_data` changes only when a read burst completes normally.
- R11: A mode write or data access while `busy` is high is ignored. When a mode write and a data access arrive together while idle, the data access wins and the mode write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_wdata | input | 32 | Mode word value |
| dat_we | input | 1 | Data write; starts a write burst |
| dat_wdata | input | 32 | Data word to send |
| dat_re | input | 1 | Data read; starts a read burst |
| rd_data | output | 32 | Last completed read word |
| busy | output | 1 | Burst in progress |
| ack_err | output | 1 | Sticky acknowledge timeout flag |
| bus_slave | output | 4 | Slave address |
| bus_sub | output | 3 | Register sub-address |
| bus_cs | output | 1 | Chip select |
| bus_strobe | output | 1 | Data strobe |
| bus_rd | output | 1 | Direction, high for read |
| bus_dout | output | 8 | Byte to the slave |
| bus_din | input | 8 | Byte from the slave |
| bus_ack_sync | input | 1 | Synchronous acknowledge |
| bus_ack_async | input | 1 | Asynchronous acknowledge |
| bus_swap | output | 1 | Slave-side byte order select |

## Verification
Write bursts of three and four bytes, with and without packing and with the order reversed, show whether byte selection follows the left-justified rule or shifts or reverses wrongly. Sub-address stepping is tried across the 7-to-0 wrap and over two bursts with no mode write between them, which separates a counter kept in the mode state from one that restarts per burst. A timed burst, a synchronous and an asynchronous acknowledge each give a different strobe length and `busy` length, so the two acknowledge paths and the zero-width rule cannot be mistaken for each other. A reserved-slave burst, a timeout read and writes made while busy show the side effects that must not happen.

// File: rtl/dbm_pkg.sv
`timescale 1ns/1ps
package dbm_pkg;
  localparam int DATA_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int LANES    = DATA_W / BYTE_W;
  localparam int TIM_W    = 5;
  localparam int SUB_W    = 3;
  localparam int SLV_W    = 4;
  localparam logic [SLV_W-1:0] SLV_RESERVED = 4'hF;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  typedef struct packed {
    logic             swap;
    logic [TIM_W-1:0] setup;
    logic [TIM_W-1:0] hold;
    logic [TIM_W-1:0] width;
    logic             aack;
    logic             sack;
    logic [SLV_W-1:0] slave;
    logic [SUB_W-1:0] sub;
    logic             inc;
    logic             pack;
    logic [1:0]       cnt;
  } mode_t;

  function automatic mode_t unpack_mode(input logic [DATA_W-1:0] w);
    mode_t m;
    m.cnt   = w[1:0];
    m.pack  = w[2];
    m.inc   = w[3];
    m.sub   = w[6:4];
    m.slave = w[10:7];
    m.sack  = w[11];
    m.aack  = w[12];
    m.width = w[17:13];
    m.hold  = w[22:18];
    m.setup = w[27:23];
    m.swap  = w[28];
    return m;
  endfunction
endpackage

// File: rtl/dbm_cycle_timer.sv
`timescale 1ns/1ps
module dbm_cycle_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // phase ends in the cycle holding the final count
  assign expire = (cnt_q <= CW'(1));

  // R7: a phase is never started with a zero length
  a_r7_load_nonzero: assert property (@(posedge clk) disable iff (rst)
    load |-> (val != '0));
endmodule

// File: rtl/dbm_ack_sync.sv
`timescale 1ns/1ps
module dbm_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_sync_i,
  input  logic ack_async_i,
  input  logic en_sync,
  input  logic en_async,
  output logic seen
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= ack_async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], ack_async_i};
      end
    end
  endgenerate

  assign seen = (en_sync & ack_sync_i) | (en_async & sh_q[STAGES-1]);
endmodule

// File: rtl/dbm_byte_lane.sv
`timescale 1ns/1ps
module dbm_byte_lane #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int IW     = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] tx_word,
  input  logic [DATA_W-1:0] acc_word,
  input  logic [IW-1:0]     idx,
  input  logic [IW:0]       nbytes,
  input  logic              swap,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [DATA_W-1:0] acc_ins
);
  logic [IW:0]        pos_w;
  logic [LANES-1:0]   hit;
  logic [BYTE_W-1:0]  masked [LANES];

  assign pos_w = swap ? (nbytes - (IW+1)'(1) - {1'b0, idx}) : {1'b0, idx};

  // lane g holds left-justified position LANES-1-g
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = (pos_w == (IW+1)'(LANES-1-g));
    assign acc_ins[g*BYTE_W +: BYTE_W] = hit[g] ? rx_byte : acc_word[g*BYTE_W +: BYTE_W];
    assign masked[g] = hit[g] ? tx_word[g*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    tx_byte = '0;
    for (int i = 0; i < LANES; i++) tx_byte = tx_byte | masked[i];
    // R3: at most one lane is addressed per byte
    a_r3_one_lane: assert ($onehot0(hit));
  end
endmodule

// File: rtl/dispbus_master.sv
`timescale 1ns/1ps
module dispbus_master
  import dbm_pkg::*;
#(
  parameter int ACK_TIMEOUT = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              dat_re,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              ack_err,
  output logic [SLV_W-1:0]  bus_slave,
  output logic [SUB_W-1:0]  bus_sub,
  output logic              bus_cs,
  output logic              bus_strobe,
  output logic              bus_rd,
  output logic [BYTE_W-1:0] bus_dout,
  input  logic [BYTE_W-1:0] bus_din,
  input  logic              bus_ack_sync,
  input  logic              bus_ack_async,
  output logic              bus_swap
);
  localparam int IW = $clog2(LANES);
  localparam int TW = $clog2(ACK_TIMEOUT + 1);
  localparam int MODE_W = 29;

  phase_e            st_q, st_nx;
  logic [DATA_W-1:0] mode_q, word_q, acc_q, rd_data_q;
  logic [IW-1:0]     idx_q;
  logic [IW:0]       nb_q, nb_w;
  logic              rd_q, err_q;
  mode_t             m;
  logic              rsv, ack_mode, ack_seen, ph_exp, tmo_exp, last;
  logic [TIM_W-1:0]  weff, ph_val;
  logic              ph_ld, tmo_ld, accept, go_byte, go_strobe, strb_end, after_hold, xfer_end, abort;
  logic [BYTE_W-1:0] tx_byte;
  logic [DATA_W-1:0] acc_ins, acc_fin;
  logic              unused_mode_bits;

  assign unused_mode_bits = ^mode_q[DATA_W-1:MODE_W];

  assign m        = unpack_mode(mode_q);
  assign rsv      = (m.slave == SLV_RESERVED);
  assign ack_mode = (m.sack | m.aack) & ~rsv;
  assign weff     = (m.width == '0) ? TIM_W'(1) : m.width;
  assign nb_w     = (m.pack || m.cnt == 2'd0) ? (IW+1)'(LANES) : (IW+1)'(m.cnt);
  assign last     = ({1'b0, idx_q} == nb_q - (IW+1)'(1));

  dbm_cycle_timer #(.CW(TIM_W)) u_phase (
    .clk(clk), .rst(rst), .load(ph_ld), .val(ph_val), .expire(ph_exp));

  dbm_cycle_timer #(.CW(TW)) u_tmo (
    .clk(clk), .rst(rst), .load(tmo_ld), .val(TW'(ACK_TIMEOUT)), .expire(tmo_exp));

  dbm_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
    .clk(clk), .rst(rst), .ack_sync_i(bus_ack_sync), .ack_async_i(bus_ack_async),
    .en_sync(m.sack & ~rsv), .en_async(m.aack & ~rsv), .seen(ack_seen));

  dbm_byte_lane #(.BYTE_W(BYTE_W), .LANES(LANES)) u_lane (
    .tx_word(word_q), .acc_word(acc_q), .idx(idx_q), .nbytes(nb_q), .swap(m.swap),
    .rx_byte(bus_din), .tx_byte(tx_byte), .acc_ins(acc_ins));

  // phase sequencing: strobe end -> hold -> next byte -> setup -> strobe
  always_comb begin
    st_nx = st_q; ph_ld = 1'b0; ph_val = '0; tmo_ld = 1'b0;
    accept = 1'b0; go_byte = 1'b0; go_strobe = 1'b0; strb_end = 1'b0;
    after_hold = 1'b0; xfer_end = 1'b0; abort = 1'b0;
    case (st_q)
      PH_IDLE:   if (dat_we || dat_re) begin accept = 1'b1; go_byte = 1'b1; end
      PH_SETUP:  if (ph_exp) go_strobe = 1'b1;
      PH_STROBE: begin
        if (ack_mode) begin
          if (ack_seen)     strb_end = 1'b1;
          else if (tmo_exp) abort = 1'b1;
        end else if (ph_exp) strb_end = 1'b1;
      end
      PH_HOLD:   if (ph_exp) after_hold = 1'b1;
      default:   st_nx = PH_IDLE;
    endcase
    if (strb_end) begin
      if (m.hold != '0) begin st_nx = PH_HOLD; ph_ld = 1'b1; ph_val = m.hold; end
      else after_hold = 1'b1;
    end
    if (after_hold) begin
      if (last) begin st_nx = PH_IDLE; xfer_end = 1'b1; end
      else go_byte = 1'b1;
    end
    if (go_byte) begin
      if (m.setup != '0) begin st_nx = PH_SETUP; ph_ld = 1'b1; ph_val = m.setup; end
      else go_strobe = 1'b1;
    end
    if (go_strobe) begin st_nx = PH_STROBE; ph_ld = 1'b1; ph_val = weff; tmo_ld = 1'b1; end
    if (abort) st_nx = PH_IDLE;
  end

  assign acc_fin = strb_end ? acc_ins : acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= PH_IDLE; mode_q <= '0; word_q <= '0; acc_q <= '0; rd_data_q <= '0;
      idx_q <= '0; nb_q <= '0; rd_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_nx;
      if (cfg_we && st_q == PH_IDLE && !accept) mode_q <= cfg_wdata;
      if (accept) begin
        word_q <= dat_wdata; rd_q <= ~dat_we; idx_q <= '0; acc_q <= '0; nb_q <= nb_w;
      end
      if (strb_end) begin
        if (rd_q)  acc_q <= acc_ins;
        if (m.inc) mode_q[6:4] <= mode_q[6:4] + 3'd1;
      end
      if (after_hold && !last) idx_q <= idx_q + 1'b1;
      if (xfer_end && rd_q) rd_data_q <= acc_fin;
      if (abort) err_q <= 1'b1;
    end
  end

  assign busy       = (st_q != PH_IDLE);
  assign bus_cs     = busy & ~rsv;
  assign bus_strobe = (st_q == PH_STROBE) & ~rsv;
  assign bus_rd     = busy & rd_q;
  assign bus_dout   = (busy && !rd_q) ? tx_byte : '0;
  assign bus_slave  = m.slave;
  assign bus_sub    = m.sub;
  assign bus_swap   = m.swap;
  assign rd_data    = rd_data_q;
  assign ack_err    = err_q;

  // R11: mode fields other than the sub-address hold still through a burst
  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(mode_q[31:7]) && $stable(mode_q[3:0])));
  // R9: the timeout flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    ack_err |=> ack_err);
  // R6: reserved slave code stays silent on the bus
  a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (busy && m.slave == SLV_RESERVED) |-> (!bus_cs && !bus_strobe));
  // R8: an acknowledged strobe waits for its acknowledge or the timeout
  a_r8_wait_ack: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_STROBE && ack_mode && !ack_seen && !tmo_exp) |=> (st_q == PH_STROBE));
  // R7: with a nonzero setup the strobe is preceded by the setup phase
  a_r7_setup_first: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_strobe) && m.setup != '0) |-> ($past(st_q) == PH_SETUP));
  // R10: the read result only moves while a burst is running
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(rd_data));
endmodule

// File: tb/tb_dispbus_master.sv
`timescale 1ns/1ps
module tb_dispbus_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
  logic [31:0] cfg_wdata = '0, dat_wdata = '0;
  logic [31:0] rd_data;
  logic        busy, ack_err, bus_cs, bus_strobe, bus_rd, bus_swap;
  logic [3:0]  bus_slave;
  logic [2:0]  bus_sub;
  logic [7:0]  bus_dout, bus_din;
  logic        ack_s = 1'b0, ack_a = 1'b0;

  always #2 clk = ~clk;

  dispbus_master dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re), .rd_data(rd_data),
    .busy(busy), .ack_err(ack_err), .bus_slave(bus_slave), .bus_sub(bus_sub),
    .bus_cs(bus_cs), .bus_strobe(bus_strobe), .bus_rd(bus_rd), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_ack_sync(ack_s), .bus_ack_async(ack_a), .bus_swap(bus_swap));

  // slave model: returned byte depends on the sub-address
  assign bus_din = 8'h40 + 8'(bus_sub) * 8'h13;

  typedef struct {
    logic [3:0] slv;
    logic [2:0] sub;
    logic       rd;
    logic [7:0] dout;
    int         len;
  } item_t;
  item_t expq[$];

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int cnt, int pack, int inc, int sub, int slv, int sa,
                                     int aa, int w, int h, int s, int sw);
    logic [31:0] v = '0;
    v[1:0] = 2'(cnt); v[2] = 1'(pack); v[3] = 1'(inc); v[6:4] = 3'(sub);
    v[10:7] = 4'(slv); v[11] = 1'(sa); v[12] = 1'(aa); v[17:13] = 5'(w);
    v[22:18] = 5'(h); v[27:23] = 5'(s); v[28] = 1'(sw);
    return v;
  endfunction

  // acknowledge responder: 0 none, 1 sync, 2 async
  int ack_mode = 0;
  int ack_delay = 3;
  int stb_age = 0;
  always @(negedge clk) begin
    if (bus_strobe) begin
      stb_age++;
      if (stb_age == ack_delay) begin
        if (ack_mode == 1) ack_s <= 1'b1;
        if (ack_mode == 2) ack_a <= 1'b1;
      end
    end else begin
      stb_age = 0; ack_s <= 1'b0; ack_a <= 1'b0;
    end
  end

  // monitor: pops one expected byte per strobe pulse
  logic  stb_prev = 1'b0;
  int    len = 0;
  int    cs_cnt = 0;
  bit    have = 0;
  item_t cur;
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_strobe && !stb_prev) begin
        if (expq.size() == 0) chk(0, "R11 unexpected strobe", 32'(bus_slave), 32'hx);
        else begin
          cur = expq.pop_front(); have = 1;
          chk(bus_slave == cur.slv, "R6 slave address", 32'(bus_slave), 32'(cur.slv));
          chk(bus_cs, "R6 chip select during strobe", 32'(bus_cs), 32'd1);
          chk(bus_sub == cur.sub, "R5 sub-address", 32'(bus_sub), 32'(cur.sub));
          chk(bus_rd == cur.rd, "R10 direction", 32'(bus_rd), 32'(cur.rd));
          if (!cur.rd) chk(bus_dout == cur.dout, "R3 write byte", 32'(bus_dout), 32'(cur.dout));
        end
        len = 1;
      end else if (bus_strobe) len++;
      else if (stb_prev && have) begin
        chk(len == cur.len, "R7 strobe length", 32'(len), 32'(cur.len));
        have = 0;
      end
      if (bus_cs) cs_cnt++;
      stb_prev = bus_strobe;
    end
  end

  logic [31:0] bm = '0;

  task automatic xfer(input bit do_mode, input logic [31:0] mode, input bit rd,
                      input logic [31:0] data, input int slen, input int exp_busy,
                      input bit poke, input logic [31:0] pmode, input string tag,
                      output logic [31:0] exp_rd);
    int n, pos, cnt;
    logic [2:0] s;
    item_t it;
    if (do_mode) begin
      cfg_we = 1'b1; cfg_wdata = mode; @(negedge clk); cfg_we = 1'b0; bm = mode;
    end
    n = (bm[2] || bm[1:0] == 2'd0) ? 4 : int'(bm[1:0]);
    s = bm[6:4];
    exp_rd = '0;
    for (int i = 0; i < n; i++) begin
      pos = bm[28] ? n - 1 - i : i;
      it.slv = bm[10:7]; it.sub = s; it.rd = rd; it.dout = data[31-8*pos -: 8]; it.len = slen;
      exp_rd[31-8*pos -: 8] = 8'h40 + 8'(s) * 8'h13;
      if (bm[10:7] != 4'hF) expq.push_back(it);
      if (bm[3]) s = s + 3'd1;
    end
    bm[6:4] = s;
    if (rd) dat_re = 1'b1; else begin dat_we = 1'b1; dat_wdata = data; end
    @(negedge clk);
    dat_re = 1'b0; dat_we = 1'b0;
    cnt = 0;
    while (busy && cnt < 2000) begin
      cnt++;
      if (poke && cnt == 1) begin
        cfg_we = 1'b1; cfg_wdata = pmode; dat_we = 1'b1; dat_wdata = 32'hFFFF_FFFF;
      end else begin
        cfg_we = 1'b0; dat_we = 1'b0;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0; dat_we = 1'b0;
    chk(cnt == exp_busy, {"R7 busy cycles ", tag}, 32'(cnt), 32'(exp_busy));
    chk(expq.size() == 0, {"R2 byte count ", tag}, 32'(expq.size()), 32'd0);
  endtask

  initial begin
    logic [31:0] er, saved;
    int cs0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !bus_cs && !bus_strobe, "R1 idle outputs", {busy, bus_cs, bus_strobe}, 32'd0);
    chk(!ack_err && rd_data == '0, "R1 error and read data", rd_data | 32'(ack_err), 32'd0);

    // R2 R3 R6 R7: three bytes, timed
    xfer(1, mk(3,0,0,2,3,0,0,3,1,2,0), 0, 32'hA1B2C3D4, 3, 18, 0, '0, "three-byte", er);
    // R2 R5: packed four bytes, sub-address wraps 6,7,0,1
    xfer(1, mk(1,1,1,6,5,0,0,1,1,0,0), 0, 32'h11223344, 1, 8, 0, '0, "packed", er);
    // R5 R11: no mode write, sub continues at 2; writes while busy ignored
    xfer(0, '0, 0, 32'h55667788, 1, 8, 1, mk(1,0,0,0,9,0,0,1,1,0,0), "poke", er);
    // R11: earlier ignored mode write must not show up here
    xfer(0, '0, 0, 32'h01020304, 1, 8, 0, '0, "after-poke", er);
    // R4: reversed order
    xfer(1, mk(3,0,0,0,2,0,0,2,0,1,1), 0, 32'hA1B2C3D4, 2, 9, 0, '0, "swap", er);
    // R10: two-byte read with stepping sub-address 1,2
    xfer(1, mk(2,0,1,1,4,0,0,2,1,1,0), 1, '0, 2, 8, 0, '0, "read", er);
    chk(rd_data == er, "R10 read word", rd_data, er);
    chk(er == 32'h5366_0000, "R10 expected read word", er, 32'h5366_0000);
    saved = rd_data;
    // R6: reserved slave, acknowledge enabled but not awaited
    cs0 = cs_cnt;
    xfer(1, mk(1,0,0,3,15,1,0,2,1,1,0), 0, 32'hCAFE0000, 2, 4, 0, '0, "reserved", er);
    chk(cs_cnt == cs0, "R6 no chip select for reserved slave", 32'(cs_cnt - cs0), 32'd0);
    // R8: synchronous acknowledge
    ack_mode = 1;
    xfer(1, mk(1,0,0,0,1,1,0,0,2,1,0), 0, 32'h7E000000, 3, 6, 0, '0, "sync-ack", er);
    // R8: asynchronous acknowledge, two cycles of synchronizer
    ack_mode = 2;
    xfer(1, mk(1,0,0,0,1,0,1,0,2,1,0), 0, 32'h3C000000, 5, 8, 0, '0, "async-ack", er);
    // R9: no acknowledge on a read
    ack_mode = 0;
    chk(!ack_err, "R9 error clear before timeout", 32'(ack_err), 32'd0);
    xfer(1, mk(1,0,0,0,1,1,0,0,2,1,0), 1, '0, 256, 257, 0, '0, "timeout", er);
    chk(ack_err, "R9 error set by timeout", 32'(ack_err), 32'd1);
    chk(rd_data == saved, "R10 read word kept on abort", rd_data, saved);
    // R9: error stays through a normal burst
    xfer(1, mk(1,0,0,0,1,0,0,1,0,0,0), 0, 32'h99000000, 1, 1, 0, '0, "after-timeout", er);
    chk(ack_err, "R9 error sticky", 32'(ack_err), 32'd1);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule